// File: doc/BRIEF.md
# Signed Division Unit

A register-mapped signed integer divider. Software loads a divisor, then writes a dividend to one of two launch registers. A write to the single-word dividend register divides that word by the divisor. A write to the low half of a double-word dividend divides the pair {high word, low word} by the divisor, where the high word is whatever was written there earlier. Quotient and remainder land in a result register pair and in a second read-only pair that mirrors it. The single-word launch also writes the quotient back into the dividend register.

The arithmetic is a restoring shift-subtract loop on magnitudes, one quotient bit per clock, with sign correction at the end. Quotients truncate toward zero and remainders carry the sign of the dividend. A quotient that does not fit in a signed word saturates to the largest positive or most negative value. A zero divisor clears the four result registers at once and never raises busy. While the unit is busy it ignores writes to its operand registers, and software can poll a status word to see when it is free.

Top module: `sdiv_unit`

## Requirements
- R1: After reset every register (divisor 0x00, dividend 0x04, status 0x08, high 0x10, low 0x14, mirror-high 0x18, mirror-low 0x1C) reads 0, and busy is 0.
- R2: Writes to 0x00 and 0x10 store the word, which reads back unchanged. Writes to 0x08, 0x18 and 0x1C change nothing. Address bits [1:0] are ignored, and unmapped offsets read 0.
- R3: With a nonzero divisor, a write to 0x04 stores the word and starts a signed single-word division. Busy is high for 33 cycles after the write edge (W+1 when the short path is enabled). At the end the quotient is in 0x04, 0x14 and 0x1C, and the remainder is in 0x10 and 0x18.
- R4: With a nonzero divisor, a write to 0x14 starts a signed division of {0x10, 0x14} by 0x00. Busy is high for 65 cycles (2W+1). At the end the remainder is in 0x10 and 0x18, the quotient is in 0x14 and 0x1C, and 0x04 is unchanged.
- R5: The quotient truncates toward zero. The remainder is zero or has the sign of the dividend, and its magnitude is less than that of the divisor.
- R6: A quotient above 0x7FFFFFFF saturates to 0x7FFFFFFF, and one below -2^31 saturates to 0x80000000, in both modes (so 0x80000000 / -1 gives 0x7FFFFFFF). The remainder is still the true remainder.
- R7: A launch write while the divisor is 0 clears 0x10, 0x14, 0x18 and 0x1C at that clock edge. Busy stays 0, and the written word is kept in 0x04 when the launch is through 0x04.
- R8: While busy, writes to 0x00, 0x04, 0x10 and 0x14 are ignored: nothing is stored and no new division starts.
- R9: The status word at 0x08 reads 1 in bit 0 while busy and 0 otherwise, and its other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| addr | input | 5 | Byte offset; bits [4:2] select the register |
| wdata | input | W | Write data |
| rdata | output | W | Read data for addr, combinational |
| busy | output | 1 | Division in progress |

## Verification
A wrong bit in the shift-subtract state appears as a wrong quotient or remainder as soon as busy drops, 33 or 65 cycles after launch. The remainder bound and sign checks catch it even for operands the vector table never tried. A bad step counter shows up as a busy pulse of the wrong length at the first completion. A launch or store that leaks through while busy shows up one edge later as a changed divisor, or at the end as results that belong to different operands. Saturation and the zero-divisor clear are driven directly with the most negative dividend over -1, power-of-two boundaries, and a zero divisor on both launch registers.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
   localparam int unsigned ADDR_W = 5;

   // register slot selected by addr[4:2]
   typedef enum logic [2:0] {
      SLOT_DIVISOR = 3'd0,
      SLOT_DVD32   = 3'd1,
      SLOT_STATUS  = 3'd2,
      SLOT_SPARE   = 3'd3,
      SLOT_HIGH    = 3'd4,
      SLOT_LOW     = 3'd5,
      SLOT_MIR_HI  = 3'd6,
      SLOT_MIR_LO  = 3'd7
   } slot_e;
endpackage

// File: rtl/sdiv_operand.sv
module sdiv_operand #(
   parameter int W = 32
) (
   input  logic           is_short,
   input  logic [W-1:0]   dvd_lo,
   input  logic [W-1:0]   dvd_hi,
   input  logic [W-1:0]   dsr,
   output logic [2*W-1:0] dvd_mag,
   output logic [W-1:0]   dsr_mag,
   output logic           dvd_neg,
   output logic           quo_neg
);
   localparam int SW = 2 * W;

   logic [SW-1:0] dvd_full;
   logic          dsr_neg;

   assign dvd_full = is_short ? {{W{dvd_lo[W-1]}}, dvd_lo} : {dvd_hi, dvd_lo};
   assign dvd_neg  = dvd_full[SW-1];
   assign dsr_neg  = dsr[W-1];
   assign dvd_mag  = dvd_neg ? -dvd_full : dvd_full;
   assign dsr_mag  = dsr_neg ? -dsr : dsr;
   assign quo_neg  = dvd_neg ^ dsr_neg;
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
   parameter int W          = 32,
   parameter bit FAST_SHORT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           is_short,
   input  logic [2*W-1:0] dvd_mag,
   input  logic [W-1:0]   dsr_mag,
   output logic           done,
   output logic [2*W-1:0] quo_mag,
   output logic [W-1:0]   rem_mag
);
   localparam int SW    = 2 * W;
   localparam int CNT_W = $clog2(SW + 1);

   logic [W-1:0]     rem_q;
   logic [SW-1:0]    acc_q;
   logic [W-1:0]     dsr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [W:0]       shifted;
   logic [W+1:0]     diff;
   logic             fits;
   logic [SW-1:0]    load_acc;
   logic [CNT_W-1:0] load_cnt;
   logic             unused_diff;

   assign shifted     = {rem_q, acc_q[SW-1]};
   assign diff        = {1'b0, shifted} - {2'b00, dsr_q};
   assign fits        = ~diff[W+1];
   assign unused_diff = diff[W];

   generate
      if (FAST_SHORT) begin : g_fast
         // a sign-extended single word has an all-zero upper magnitude
         assign load_acc = is_short ? {dvd_mag[W-1:0], {W{1'b0}}} : dvd_mag;
         assign load_cnt = is_short ? CNT_W'(W) : CNT_W'(SW);
      end else begin : g_full
         logic unused_short;
         assign unused_short = is_short;
         assign load_acc     = dvd_mag;
         assign load_cnt     = CNT_W'(SW);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         acc_q <= '0;
         dsr_q <= '0;
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rem_q <= '0;
            acc_q <= load_acc;
            dsr_q <= dsr_mag;
            cnt_q <= load_cnt;
         end else if (cnt_q != '0) begin
            rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
            acc_q <= {acc_q[SW-2:0], fits};
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) done <= 1'b1;
         end
      end
   end

   assign quo_mag = acc_q;
   assign rem_mag = rem_q;
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup #(
   parameter int W = 32
) (
   input  logic [2*W-1:0] quo_mag,
   input  logic [W-1:0]   rem_mag,
   input  logic           quo_neg,
   input  logic           rem_neg,
   output logic [W-1:0]   quo,
   output logic [W-1:0]   rem
);
   localparam int SW = 2 * W;
   localparam logic [SW-1:0] POS_LIM = {{(W+1){1'b0}}, {(W-1){1'b1}}};
   localparam logic [SW-1:0] NEG_LIM = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0]  MAX_V   = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0]  MIN_V   = {1'b1, {(W-1){1'b0}}};

   logic ovf;

   assign ovf = quo_neg ? (quo_mag > NEG_LIM) : (quo_mag > POS_LIM);

   always_comb begin
      if (ovf)          quo = quo_neg ? MIN_V : MAX_V;
      else if (quo_neg) quo = -quo_mag[W-1:0];
      else              quo = quo_mag[W-1:0];
      rem = rem_neg ? -rem_mag : rem_mag;
   end
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit #(
   parameter int W          = 32,
   parameter bit FAST_SHORT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [sdiv_pkg::ADDR_W-1:0] addr,
   input  logic [W-1:0]              wdata,
   output logic [W-1:0]              rdata,
   output logic                      busy
);
   import sdiv_pkg::*;

   localparam int SW = 2 * W;

   initial begin : p_param_chk
      if (W < 8) $error("sdiv_unit: W must be at least 8");
   end

   logic [W-1:0] div_q, dvd_q, hi_q, lo_q, mhi_q, mlo_q;
   logic         busy_q, short_q, quo_neg_q, rem_neg_q;
   slot_e        slot;
   logic         wr_ok, launch_any, zero_dsr, launch, is_short;
   logic [SW-1:0] dvd_mag, quo_mag;
   logic [W-1:0]  dsr_mag, rem_mag, quo_fix, rem_fix;
   logic          dvd_neg, quo_neg, core_done;
   logic [1:0]    unused_lsb;

   assign unused_lsb = addr[1:0];
   assign slot       = slot_e'(addr[4:2]);
   assign wr_ok      = wr_en & ~busy_q;
   assign is_short   = (slot == SLOT_DVD32);
   assign launch_any = wr_ok & ((slot == SLOT_DVD32) | (slot == SLOT_LOW));
   assign zero_dsr   = (div_q == '0);
   assign launch     = launch_any & ~zero_dsr;

   sdiv_operand #(.W(W)) u_operand (
      .is_short (is_short),
      .dvd_lo   (wdata),
      .dvd_hi   (hi_q),
      .dsr      (div_q),
      .dvd_mag  (dvd_mag),
      .dsr_mag  (dsr_mag),
      .dvd_neg  (dvd_neg),
      .quo_neg  (quo_neg)
   );

   sdiv_core #(.W(W), .FAST_SHORT(FAST_SHORT)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (launch),
      .is_short (is_short),
      .dvd_mag  (dvd_mag),
      .dsr_mag  (dsr_mag),
      .done     (core_done),
      .quo_mag  (quo_mag),
      .rem_mag  (rem_mag)
   );

   sdiv_fixup #(.W(W)) u_fixup (
      .quo_mag  (quo_mag),
      .rem_mag  (rem_mag),
      .quo_neg  (quo_neg_q),
      .rem_neg  (rem_neg_q),
      .quo      (quo_fix),
      .rem      (rem_fix)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q     <= '0;
         dvd_q     <= '0;
         hi_q      <= '0;
         lo_q      <= '0;
         mhi_q     <= '0;
         mlo_q     <= '0;
         busy_q    <= 1'b0;
         short_q   <= 1'b0;
         quo_neg_q <= 1'b0;
         rem_neg_q <= 1'b0;
      end else if (core_done) begin
         hi_q   <= rem_fix;
         mhi_q  <= rem_fix;
         lo_q   <= quo_fix;
         mlo_q  <= quo_fix;
         if (short_q) dvd_q <= quo_fix;
         busy_q <= 1'b0;
      end else if (wr_ok) begin
         case (slot)
            SLOT_DIVISOR: div_q <= wdata;
            SLOT_HIGH:    hi_q  <= wdata;
            SLOT_DVD32, SLOT_LOW: begin
               if (is_short) dvd_q <= wdata;
               else          lo_q  <= wdata;
               if (zero_dsr) begin
                  hi_q  <= '0;
                  lo_q  <= '0;
                  mhi_q <= '0;
                  mlo_q <= '0;
               end else begin
                  busy_q    <= 1'b1;
                  short_q   <= is_short;
                  quo_neg_q <= quo_neg;
                  rem_neg_q <= dvd_neg;
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (slot)
         SLOT_DIVISOR: rdata = div_q;
         SLOT_DVD32:   rdata = dvd_q;
         SLOT_STATUS:  rdata = {{(W-1){1'b0}}, busy_q};
         SLOT_HIGH:    rdata = hi_q;
         SLOT_LOW:     rdata = lo_q;
         SLOT_MIR_HI:  rdata = mhi_q;
         SLOT_MIR_LO:  rdata = mlo_q;
         default:      rdata = '0;
      endcase
   end

   assign busy = busy_q;
endmodule

// File: rtl/sdiv_unit_chk.sv
module sdiv_unit_chk #(
   parameter int W          = 32,
   parameter bit FAST_SHORT = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic [2:0]   slot,
   input logic [W-1:0] wdata,
   input logic         busy,
   input logic [W-1:0] div_q,
   input logic [W-1:0] hi_q,
   input logic [W-1:0] lo_q,
   input logic [W-1:0] mhi_q,
   input logic [W-1:0] mlo_q
);
   localparam logic [15:0] LEN_SHORT = FAST_SHORT ? 16'(W + 1) : 16'(2 * W + 1);
   localparam logic [15:0] LEN_LONG  = 16'(2 * W + 1);

   logic        launch_c, sign_q, long_q;
   logic [15:0] cnt_q;
   logic [W-1:0] rem_abs, dsr_abs;

   assign launch_c = wr_en & ~busy & ((slot == 3'd1) | (slot == 3'd5)) & (div_q != '0);
   assign rem_abs  = hi_q[W-1] ? -hi_q : hi_q;
   assign dsr_abs  = div_q[W-1] ? -div_q : div_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sign_q <= 1'b0;
         long_q <= 1'b0;
         cnt_q  <= '0;
      end else if (launch_c) begin
         sign_q <= (slot == 3'd1) ? wdata[W-1] : hi_q[W-1];
         long_q <= (slot == 3'd5);
         cnt_q  <= '0;
      end else if (busy) begin
         cnt_q  <= cnt_q + 16'd1;
      end
   end

   // R3 / R4: busy length per launch type
   a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (cnt_q == (long_q ? LEN_LONG : LEN_SHORT)));

   // R5: remainder sign follows dividend
   a_r5_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (hi_q == '0 || hi_q[W-1] == sign_q));

   // R5: remainder magnitude below divisor magnitude
   a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (rem_abs < dsr_abs));

   // R7: zero divisor clears results without busy
   a_r7_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_en && (slot == 3'd1 || slot == 3'd5) && div_q == '0)
      |=> (!busy && hi_q == '0 && lo_q == '0 && mhi_q == '0 && mlo_q == '0));

   // R8: divisor frozen during a division
   a_r8_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && slot == 3'd0) |=> (div_q == $past(div_q)));
endmodule

bind sdiv_unit sdiv_unit_chk #(.W(W), .FAST_SHORT(FAST_SHORT)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_en (wr_en),
   .slot  (addr[4:2]),
   .wdata (wdata),
   .busy  (busy_q),
   .div_q (div_q),
   .hi_q  (hi_q),
   .lo_q  (lo_q),
   .mhi_q (mhi_q),
   .mlo_q (mlo_q)
);

// File: tb/sdiv_unit_tb.sv
module sdiv_unit_tb;
   localparam int W = 32;

   typedef struct packed {
      logic        lng;
      logic [31:0] hi;
      logic [31:0] lo;
      logic [31:0] dsr;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'h0,        32'd100,      32'd7},
      '{1'b0, 32'h0,        32'hFFFFFF9C, 32'd7},
      '{1'b0, 32'h0,        32'd100,      32'hFFFFFFF9},
      '{1'b0, 32'h0,        32'hFFFFFF9C, 32'hFFFFFFF9},
      '{1'b0, 32'h0,        32'h80000000, 32'hFFFFFFFF},
      '{1'b0, 32'h0,        32'h80000000, 32'd1},
      '{1'b0, 32'h0,        32'd5,        32'h80000000},
      '{1'b1, 32'h1,        32'h0,        32'd3},
      '{1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'd2},
      '{1'b1, 32'hFFFFFFFF, 32'h80000000, 32'd1},
      '{1'b1, 32'h0,        32'h80000000, 32'd1},
      '{1'b1, 32'h80000000, 32'h0,        32'hFFFFFFFF},
      '{1'b1, 32'hFFFFFFFF, 32'hFFFFFFF9, 32'd2},
      '{1'b1, 32'h12345678, 32'h9ABCDEF0, 32'h7FFFFFFF}
   };

   logic         clk = 1'b0;
   logic         rst_n;
   logic         wr_en;
   logic [4:0]   addr;
   logic [W-1:0] wdata;
   logic [W-1:0] rdata;
   logic         busy;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   sdiv_unit #(.W(W)) u_dut (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata),
      .busy  (busy)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   function automatic void ref_div(input logic lng, input logic [31:0] hi, input logic [31:0] lo,
                                   input logic [31:0] dsr, output logic [31:0] q,
                                   output logic [31:0] r, output logic sat);
      logic signed [95:0] n, d, qq, rr;
      n = lng ? {{32{hi[31]}}, hi, lo} : {{64{lo[31]}}, lo};
      d = {{64{dsr[31]}}, dsr};
      qq = n / d;
      rr = n % d;
      sat = 1'b1;
      if (qq > 96'sh7FFFFFFF)       q = 32'h7FFFFFFF;
      else if (qq < -96'sh80000000) q = 32'h80000000;
      else begin
         q   = qq[31:0];
         sat = 1'b0;
      end
      r = rr[31:0];
   endfunction

   initial begin : p_watchdog
      #(4 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : p_main
      logic [31:0] v, q, r, prev04;
      logic        sat;
      int          n;
      string       tag;

      rst_n = 1'b0;
      wr_en = 1'b0;
      addr  = '0;
      wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         rd(5'(a * 4), v);
         chk($sformatf("R1 reg %0d", a), v, 32'h0);
      end
      chk("R1 busy", {31'b0, busy}, 32'h0);

      // R2: plain stores and ignored writes
      wr(5'h00, 32'd7);
      rd(5'h00, v);  chk("R2 divisor", v, 32'd7);
      wr(5'h10, 32'h11223344);
      rd(5'h10, v);  chk("R2 high", v, 32'h11223344);
      wr(5'h18, 32'hDEADBEEF);
      wr(5'h1C, 32'hCAFEF00D);
      wr(5'h08, 32'hFFFFFFFF);
      rd(5'h18, v);  chk("R2 mirror hi", v, 32'h0);
      rd(5'h1C, v);  chk("R2 mirror lo", v, 32'h0);
      rd(5'h08, v);  chk("R2 status", v, 32'h0);
      rd(5'h0C, v);  chk("R2 spare", v, 32'h0);
      rd(5'h13, v);  chk("R2 low bits ignored", v, 32'h11223344);

      // vector table: R3, R4, R5, R6, R9
      for (int i = 0; i < NV; i++) begin
         ref_div(VEC[i].lng, VEC[i].hi, VEC[i].lo, VEC[i].dsr, q, r, sat);
         tag = $sformatf("%s/%s vec %0d", VEC[i].lng ? "R4" : "R3", sat ? "R6" : "R5", i);
         wr(5'h00, VEC[i].dsr);
         rd(5'h04, prev04);
         if (VEC[i].lng) begin
            wr(5'h10, VEC[i].hi);
            wr(5'h14, VEC[i].lo);
         end else begin
            wr(5'h04, VEC[i].lo);
         end
         rd(5'h08, v);
         chk({"R9 busy status ", tag}, v, 32'h1);
         wait_idle(n);
         chk({tag, " busy cycles"}, 32'(n), VEC[i].lng ? 32'd65 : 32'd33);
         rd(5'h08, v);  chk({"R9 idle status ", tag}, v, 32'h0);
         rd(5'h10, v);  chk({tag, " rem 0x10"}, v, r);
         rd(5'h18, v);  chk({tag, " rem 0x18"}, v, r);
         rd(5'h14, v);  chk({tag, " quo 0x14"}, v, q);
         rd(5'h1C, v);  chk({tag, " quo 0x1C"}, v, q);
         rd(5'h04, v);  chk({tag, " reg 0x04"}, v, VEC[i].lng ? prev04 : q);
      end

      // R7: zero divisor through 0x04
      wr(5'h00, 32'h0);
      wr(5'h04, 32'd55);
      chk("R7 no busy short", {31'b0, busy}, 32'h0);
      rd(5'h04, v);  chk("R7 keeps 0x04", v, 32'd55);
      rd(5'h10, v);  chk("R7 clear 0x10", v, 32'h0);
      rd(5'h14, v);  chk("R7 clear 0x14", v, 32'h0);
      rd(5'h18, v);  chk("R7 clear 0x18", v, 32'h0);
      rd(5'h1C, v);  chk("R7 clear 0x1C", v, 32'h0);

      // R7: zero divisor through 0x14 after repopulating results
      wr(5'h00, 32'd3);
      wr(5'h04, 32'd10);
      wait_idle(n);
      rd(5'h1C, v);  chk("R3 repopulate", v, 32'd3);
      wr(5'h00, 32'h0);
      wr(5'h10, 32'd5);
      wr(5'h14, 32'd9);
      chk("R7 no busy long", {31'b0, busy}, 32'h0);
      rd(5'h10, v);  chk("R7 long clear 0x10", v, 32'h0);
      rd(5'h14, v);  chk("R7 long clear 0x14", v, 32'h0);
      rd(5'h18, v);  chk("R7 long clear 0x18", v, 32'h0);
      rd(5'h1C, v);  chk("R7 long clear 0x1C", v, 32'h0);

      // R8: writes while busy are ignored
      wr(5'h00, 32'd7);
      wr(5'h10, 32'h0);
      rd(5'h04, prev04);
      wr(5'h14, 32'd100);
      wr(5'h00, 32'd9);
      wr(5'h10, 32'h55);
      wr(5'h04, 32'h66);
      wr(5'h14, 32'h77);
      wait_idle(n);
      rd(5'h00, v);  chk("R8 divisor kept", v, 32'd7);
      rd(5'h04, v);  chk("R8 0x04 kept", v, prev04);
      rd(5'h14, v);  chk("R8 quotient", v, 32'd14);
      rd(5'h10, v);  chk("R8 remainder", v, 32'd2);
      @(negedge clk);
      chk("R8 no relaunch", {31'b0, busy}, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule